// File: doc/BRIEF.md
# Taken-Only Branch Target Buffer

This block sits beside the fetch stage and answers one question every cycle: which PC should be fetched next? It is indexed and tagged by the PC currently being fetched. If a valid entry holds that exact PC, the block raises a hit flag and offers the stored target as the next PC, so fetch can redirect in the following cycle without waiting for decode. Otherwise it offers the sequential PC, current PC plus 4.

The buffer is direct-mapped. Only branches that resolved taken are kept in it. The execute stage reports resolved branches on a one-cycle update port:
- A taken resolution installs the branch's address and target in its slot. It overwrites whatever the slot held before.
- A not-taken resolution of a branch whose exact address is stored in its slot clears that entry.
- A not-taken resolution of any other address changes nothing.

Direction counters and the pipeline flush are left to other blocks.

Top module: `tkn_target_buf`

## Requirements
- R1: While reset is asserted, and after it is released, every entry is empty, so every fetch PC misses until a taken update has been made.
- R2: On a miss, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4`, wrapping modulo 2^32.
- R3: When a valid entry holds exactly `fetch_pc`, `pred_hit` is 1 and `pred_next_pc` equals that entry's stored target.
- R4: A taken update (`upd_en`=1, `upd_taken`=1) is seen by lookups from the cycle after the clock edge that captures it, and not in the same cycle.
- R5: The slot is selected by `pc[IDX_W+1:2]`, where IDX_W = log2(ENTRIES); with the default of 16 entries this is `pc[5:2]`. A taken update to a PC that shares the slot of a stored branch replaces that branch, and the old PC then misses.
- R6: A not-taken update (`upd_en`=1, `upd_taken`=0) whose PC exactly equals the PC stored in its slot empties that slot, and the PC then misses.
- R7: A not-taken update whose PC does not equal the PC stored in its slot leaves that entry as it was.
- R8: A hit needs all 32 PC bits to match, including bits 1:0 and every bit above the slot index.
- R9: `pred_hit` and `pred_next_pc` follow `fetch_pc` within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_pc | input | PC_W | PC of the instruction being fetched |
| upd_en | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | 1 = resolved taken, 0 = resolved not taken |
| upd_target | input | PC_W | Target of the resolved branch, used when it is taken |
| pred_hit | output | 1 | The fetch PC matched a stored entry |
| pred_next_pc | output | PC_W | Predicted next fetch PC |

## Verification
On every cycle the assertions check four things:
- A miss always offers the sequential PC.
- An empty buffer gives no hit once reset ends.
- A taken update is returned for its own PC in the cycle after it is captured.
- An eviction leaves its PC missing in the following cycle.

Other behaviour shows only in the bench's scenarios:
- Slot aliasing replaces an older branch.
- A not-taken update for an unrelated PC spares the stored entry.
- A hit is refused when the only difference is in the low bits or in the high bits.
- Outputs change within a cycle when the fetch PC changes.
- The sequential PC wraps at the top of the address space.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Action applied to one slot by the resolve-side port in a cycle
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_WRITE = 2'd1,
    UPD_EVICT = 2'd2
  } upd_act_e;

endpackage

// File: rtl/btb_rst_sync.sv
module btb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = PC_W - IDX_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);

  // Word bits pick the slot; every other bit, byte offset included, forms the tag
  assign idx = pc[IDX_W+1:2];
  assign tag = {pc[PC_W-1:IDX_W+2], pc[1:0]};

endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int TAG_W   = PC_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_target,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             wr_slot_valid,
  output logic [TAG_W-1:0] wr_slot_tag,
  input  upd_act_e         wr_act,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic               data_we;

  assign data_we = (wr_act == UPD_WRITE);

  always_comb begin
    valid_d = valid_q;
    unique case (wr_act)
      UPD_WRITE: valid_d[wr_idx] = 1'b1;
      UPD_EVICT: valid_d[wr_idx] = 1'b0;
      default:   valid_d = valid_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic slot_we;
    assign slot_we = data_we && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        tag_q[e] <= wr_tag;
        tgt_q[e] <= wr_target;
      end
    end
  end

  assign rd_valid      = valid_q[rd_idx];
  assign rd_tag        = tag_q[rd_idx];
  assign rd_target     = tgt_q[rd_idx];
  assign wr_slot_valid = valid_q[wr_idx];
  assign wr_slot_tag   = tag_q[wr_idx];

endmodule

// File: rtl/tkn_target_buf.sv
module tkn_target_buf
  import btb_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int PC_W       = 32,
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W;
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  logic             rst_q_n;
  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             rd_valid, u_slot_valid;
  logic [TAG_W-1:0] rd_tag, u_slot_tag;
  logic [PC_W-1:0]  rd_target;
  upd_act_e         upd_act;

  btb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_fetch (
    .pc(fetch_pc), .idx(f_idx), .tag(f_tag)
  );

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_upd (
    .pc(upd_pc), .idx(u_idx), .tag(u_tag)
  );

  // Resolve side: taken installs, not-taken evicts only the matching branch
  always_comb begin
    upd_act = UPD_NONE;
    if (upd_en) begin
      if (upd_taken) begin
        upd_act = UPD_WRITE;
      end else if (u_slot_valid && (u_slot_tag == u_tag)) begin
        upd_act = UPD_EVICT;
      end
    end
  end

  btb_entry_array #(
    .ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_array (
    .clk(clk), .rst_n(rst_q_n),
    .rd_idx(f_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_target(rd_target),
    .wr_idx(u_idx), .wr_slot_valid(u_slot_valid), .wr_slot_tag(u_slot_tag),
    .wr_act(upd_act), .wr_tag(u_tag), .wr_target(upd_target)
  );

  // Fetch side: pure combinational compare and select
  always_comb begin
    pred_hit     = rd_valid && (rd_tag == f_tag);
    pred_next_pc = pred_hit ? rd_target : (fetch_pc + INSN_BYTES);
  end

endmodule

// File: rtl/tkn_target_buf_chk.sv
module tkn_target_buf_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            upd_en,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target,
  input logic            pred_hit,
  input logic [PC_W-1:0] pred_next_pc
);

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pred_hit); // R1

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (pred_next_pc == fetch_pc + PC_W'(4))); // R2

  AST_TAKEN_INSTALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken) |=>
      ((fetch_pc != $past(upd_pc)) || (pred_hit && pred_next_pc == $past(upd_target)))); // R4

  AST_NOT_TAKEN_EVICTS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken) |=> ((fetch_pc != $past(upd_pc)) || !pred_hit)); // R6

endmodule

bind tkn_target_buf tkn_target_buf_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .fetch_pc(fetch_pc), .upd_en(upd_en),
  .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
  .pred_hit(pred_hit), .pred_next_pc(pred_next_pc)
);

// File: tb/tkn_target_buf_bench.sv
`timescale 1ns/1ps
module tkn_target_buf_bench;

  localparam int PC_W = 32;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] fetch_pc;
  logic            upd_en;
  logic [PC_W-1:0] upd_pc;
  logic            upd_taken;
  logic [PC_W-1:0] upd_target;
  logic            pred_hit;
  logic [PC_W-1:0] pred_next_pc;

  int n_cmp;
  int n_bad;

  tkn_target_buf u_tkn_target_buf (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .upd_en(upd_en),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
    .pred_hit(pred_hit), .pred_next_pc(pred_next_pc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        u_en;
    logic [31:0] u_pc;
    logic        u_tk;
    logic [31:0] u_tgt;
    logic [31:0] look;
    logic        e_hit;
    logic [31:0] e_next;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0,        1'b0, 32'h0,    32'h100,      1'b0, 32'h104,      8'd2}, // R2 empty buffer
    '{1'b1, 32'h100,      1'b1, 32'h2000, 32'h100,      1'b1, 32'h2000,     8'd4}, // R4 install
    '{1'b0, 32'h0,        1'b0, 32'h0,    32'h104,      1'b0, 32'h108,      8'd2}, // R2 other slot
    '{1'b1, 32'h140,      1'b1, 32'h3000, 32'h100,      1'b0, 32'h104,      8'd5}, // R5 alias replaces
    '{1'b0, 32'h0,        1'b0, 32'h0,    32'h140,      1'b1, 32'h3000,     8'd5}, // R5 new owner hits
    '{1'b1, 32'h100,      1'b0, 32'h0,    32'h140,      1'b1, 32'h3000,     8'd7}, // R7 foreign not-taken
    '{1'b1, 32'h140,      1'b0, 32'h0,    32'h140,      1'b0, 32'h144,      8'd6}, // R6 evict
    '{1'b1, 32'h208,      1'b1, 32'h10,   32'h20A,      1'b0, 32'h20E,      8'd8}, // R8 low bits differ
    '{1'b0, 32'h0,        1'b0, 32'h0,    32'h80000208, 1'b0, 32'h8000020C, 8'd8}, // R8 top bit differs
    '{1'b0, 32'h0,        1'b0, 32'h0,    32'h208,      1'b1, 32'h10,       8'd3}, // R3 exact hit
    '{1'b1, 32'hFFFFFFFC, 1'b1, 32'h4,    32'hFFFFFFFC, 1'b1, 32'h4,        8'd3}, // R3 top of space
    '{1'b0, 32'h0,        1'b0, 32'h0,    32'hFFFFFFF8, 1'b0, 32'hFFFFFFFC, 8'd2}, // R2 neighbour
    '{1'b1, 32'hFFFFFFFC, 1'b0, 32'h0,    32'hFFFFFFFC, 1'b0, 32'h0,        8'd6}, // R6 evict, wrap
    '{1'b0, 32'h0,        1'b0, 32'h0,    32'h208,      1'b1, 32'h10,       8'd7}  // R7 untouched
  };

  task automatic check(input string req, input logic hit_a, input logic [31:0] nxt_a,
                       input logic hit_e, input logic [31:0] nxt_e);
    n_cmp++;
    if (hit_a !== hit_e || nxt_a !== nxt_e) begin
      n_bad++;
      $display("FAIL %s: hit=%0b next=%08h expected hit=%0b next=%08h",
               req, hit_a, nxt_a, hit_e, nxt_e);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run=hung expected=finished");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; fetch_pc = 32'h100; upd_en = 1'b0;
    upd_pc = '0; upd_taken = 1'b0; upd_target = '0;
    repeat (3) @(negedge clk);
    #1 check("R1 during reset", pred_hit, pred_next_pc, 1'b0, 32'h104);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R1 after release", pred_hit, pred_next_pc, 1'b0, 32'h104);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      upd_en = VECS[i].u_en; upd_pc = VECS[i].u_pc;
      upd_taken = VECS[i].u_tk; upd_target = VECS[i].u_tgt;
      @(negedge clk);
      upd_en = 1'b0;
      fetch_pc = VECS[i].look;
      #1 check($sformatf("R%0d vector %0d", VECS[i].req, i), pred_hit, pred_next_pc,
               VECS[i].e_hit, VECS[i].e_next);
    end

    // R9: outputs follow fetch_pc inside one cycle
    @(negedge clk);
    fetch_pc = 32'h208;
    #1 check("R9 hit now", pred_hit, pred_next_pc, 1'b1, 32'h10);
    fetch_pc = 32'h20C;
    #1 check("R9 miss now", pred_hit, pred_next_pc, 1'b0, 32'h210);

    // R4: install not visible before the capturing edge
    @(negedge clk);
    fetch_pc = 32'h300; upd_en = 1'b1; upd_pc = 32'h300;
    upd_taken = 1'b1; upd_target = 32'h5000;
    #1 check("R4 same cycle", pred_hit, pred_next_pc, 1'b0, 32'h304);
    @(negedge clk);
    upd_en = 1'b0;
    #1 check("R4 next cycle", pred_hit, pred_next_pc, 1'b1, 32'h5000);

    // R1: reset empties a populated buffer
    @(negedge clk);
    rst_n = 1'b0; fetch_pc = 32'h208;
    #1 check("R1 reset clears", pred_hit, pred_next_pc, 1'b0, 32'h20C);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fetch_pc = 32'h300;
    #1 check("R1 stays empty", pred_hit, pred_next_pc, 1'b0, 32'h304);

    finish_run();
  end

endmodule